// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block forms the data-memory address for load and store operations in a small 8-bit processor datapath. It keeps three 16-bit pointer registers (X, Y, Z) and, on a start strobe, produces one memory request whose address is taken from a pointer, a pointer plus a small unsigned offset, a pointer adjusted by one, or a constant supplied with the operation. Each accepted operation takes exactly two clock cycles: a request cycle followed by a one-cycle done pulse.

Two of the modes change the selected pointer. Post-increment accesses with the current value and then steps the pointer up by one. Pre-decrement accesses with the value one below the current pointer and leaves the pointer at that lowered value. Either update becomes visible on the cycle after done. The displacement mode is defined only for Y and Z; asking for it on X, selecting a missing pointer, or using an undefined mode code ends the operation with an illegal flag, no memory request and no pointer change. A separate load port lets the surrounding datapath place a value in a pointer while the block is idle.

Top module: `agu_pointer_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three pointers become 0 and `mem_req`, `done` and `illegal` are 0.
- R2: With the block idle and `start` low, `ld_en` high writes `ld_val` into the pointer chosen by `ld_sel` (0 = X, 1 = Y, 2 = Z) at that edge; `ld_en` has no effect while an operation is in flight or in the same cycle as `start`.
- R3: `start` sampled high while idle gives, in the next cycle, a one-cycle `mem_req` (for a legal operation), and in the cycle after that a one-cycle `done`; `mem_req` and `done` are never high together.
- R4: Mode code 0 (plain indirect) drives `addr` with the selected pointer and leaves it unchanged.
- R5: Mode code 1 (post-increment) drives `addr` with the selected pointer; on the cycle after `done` the pointer reads one higher, 16'hFFFF wrapping to 0.
- R6: Mode code 2 (pre-decrement) drives `addr` with the selected pointer minus one; on the cycle after `done` the pointer holds that same value, 0 wrapping to 16'hFFFF.
- R7: Mode code 3 (displacement) drives `addr` with the selected pointer plus the zero-extended 6-bit `disp`, modulo 65536, and leaves the pointer unchanged; it is legal only for Y and Z.
- R8: Mode code 4 (direct) drives `addr` with `direct_addr`, ignores `ptr_sel` and changes no pointer.
- R9: Displacement mode on X, `ptr_sel` = 3 in any indirect mode, or a mode code of 5 to 7 produces no `mem_req`, a `done` pulse with `illegal` high, and no pointer change.
- R10: `start` is ignored while an operation is in flight: no extra request and no extra pointer update results.
- R11: `mem_we` is high only during `mem_req`, and then equals the `is_write` value sampled with `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 3 | Addressing mode code (0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct) |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement for mode 3 |
| direct_addr | input | 16 | Constant address for mode 4 |
| is_write | input | 1 | 1 for a store, 0 for a load |
| ld_en | input | 1 | Pointer load strobe |
| ld_sel | input | 2 | Pointer to load |
| ld_val | input | 16 | Value to load |
| addr | output | 16 | Effective address, valid while `mem_req` is high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write flag of the request |
| done | output | 1 | Operation finished (one cycle) |
| illegal | output | 1 | Operation was rejected, valid with `done` |

## Verification
The bench drives pointers onto the 16-bit edges: post-increment from 16'hFFFF and pre-decrement from 0, where a design without wrap or with the wrong adjustment order would read back 16'h10000 truncated wrongly or address the old value instead of the lowered one. Displacement is exercised with the largest offset across the wrap boundary and on X, where a design missing the legality check would issue a request and report no error. A second start and a pointer load are applied during the request cycle; a design that does not gate them would emit a third-cycle request, step Y twice or overwrite Z.

// File: rtl/agu_pkg.sv
// Shared types of the pointer address generator.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_DISP    = 3'd3,
        AM_DIRECT  = 3'd4
    } addr_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_DONE   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/agu_ptr_file.sv
// Pointer register bank.
// Holds NUM_PTR pointers of AW bits. A load port and a write-back port
// update them; the caller guarantees the two are never enabled together.
// An out-of-range read select returns zero.
module agu_ptr_file #(
    parameter int unsigned AW      = 16,
    parameter int unsigned NUM_PTR = 3,
    parameter int unsigned SW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [AW-1:0] ld_val,
    input  logic          wb_en,
    input  logic [SW-1:0] wb_sel,
    input  logic [AW-1:0] wb_val,
    input  logic [SW-1:0] rd_sel,
    output logic [AW-1:0] rd_val
);
    logic [NUM_PTR-1:0][AW-1:0] ptr_q;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        // Update one pointer from the load or write-back port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (ld_en && ld_sel == SW'(g))
                ptr_q[g] <= ld_val;
            else if (wb_en && wb_sel == SW'(g))
                ptr_q[g] <= wb_val;
        end
    end

    // Read the selected pointer.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_PTR; i++)
            if (rd_sel == SW'(i)) rd_val = ptr_q[i];
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !wb_en) |=> $stable(ptr_q)); // R9
    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && wb_en)); // R2
endmodule

// File: rtl/agu_addr_calc.sv
// Effective address and pointer update arithmetic.
// Purely combinational; all arithmetic wraps modulo 2**AW. Assumes the
// mode is legal for the selected pointer (checked by the caller).
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned QW = 6
) (
    input  addr_mode_e    mode,
    input  logic [AW-1:0] ptr_val,
    input  logic [QW-1:0] disp,
    input  logic [AW-1:0] direct_addr,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] next_ptr,
    output logic          ptr_changes
);
    logic [AW-1:0] ptr_inc;
    logic [AW-1:0] ptr_dec;
    logic [AW-1:0] ptr_off;

    assign ptr_inc = ptr_val + AW'(1);
    assign ptr_dec = ptr_val - AW'(1);
    assign ptr_off = ptr_val + AW'(disp);

    // Select address and write-back value by mode.
    always_comb begin
        eff_addr    = ptr_val;
        next_ptr    = ptr_val;
        ptr_changes = 1'b0;
        unique case (mode)
            AM_POSTINC: begin
                next_ptr    = ptr_inc;
                ptr_changes = 1'b1;
            end
            AM_PREDEC: begin
                eff_addr    = ptr_dec;
                next_ptr    = ptr_dec;
                ptr_changes = 1'b1;
            end
            AM_DISP:   eff_addr = ptr_off;
            AM_DIRECT: eff_addr = direct_addr;
            default:   eff_addr = ptr_val;
        endcase
    end
endmodule

// File: rtl/agu_seq.sv
// Two-cycle operation sequencer.
// Idle -> access (one cycle) -> done (one cycle) -> idle. Start is taken
// only in idle; it is ignored in the other two states.
module agu_seq
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic accept,
    output logic access_ph,
    output logic done_ph
);
    seq_state_e state_q;

    assign idle      = (state_q == SEQ_IDLE);
    assign accept    = idle && start;
    assign access_ph = (state_q == SEQ_ACCESS);
    assign done_ph   = (state_q == SEQ_DONE);

    // Advance the operation state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else begin
            unique case (state_q)
                SEQ_IDLE:   if (start) state_q <= SEQ_ACCESS;
                SEQ_ACCESS: state_q <= SEQ_DONE;
                default:    state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_ACCESS_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        access_ph |=> done_ph); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_ph |=> idle); // R3
endmodule

// File: rtl/agu_pointer_unit.sv
// Pointer-register address generator (top).
// Captures an operation on start, issues one memory request in the next
// cycle and a done pulse in the cycle after; pointer write-back lands at
// the end of the done cycle. Assumes the memory answers in one cycle.
module agu_pointer_unit
    import agu_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned QW      = 6,
    parameter int unsigned NUM_PTR = 3,
    parameter int unsigned SW      = 2,
    parameter int unsigned MW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] mode,
    input  logic [SW-1:0] ptr_sel,
    input  logic [QW-1:0] disp,
    input  logic [AW-1:0] direct_addr,
    input  logic          is_write,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [AW-1:0] ld_val,
    output logic [AW-1:0] addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic          done,
    output logic          illegal
);
    localparam logic [SW-1:0] SEL_X = '0;

    logic          idle, accept, access_ph, done_ph;
    logic          bad_now;
    addr_mode_e    mode_q;
    logic [SW-1:0] sel_q;
    logic [QW-1:0] disp_q;
    logic [AW-1:0] k_q;
    logic          we_q, bad_q;
    logic [AW-1:0] ptr_val, next_ptr;
    logic          ptr_changes;
    logic          ld_take, wb_en;

    // Decide legality of the incoming request.
    always_comb begin
        bad_now = 1'b0;
        if (mode > MW'(AM_DIRECT))
            bad_now = 1'b1;
        else if (mode != MW'(AM_DIRECT) && ptr_sel >= SW'(NUM_PTR))
            bad_now = 1'b1;
        else if (mode == MW'(AM_DISP) && ptr_sel == SEL_X)
            bad_now = 1'b1;
    end

    // Capture the operation fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= AM_PLAIN;
            sel_q  <= '0;
            disp_q <= '0;
            k_q    <= '0;
            we_q   <= 1'b0;
            bad_q  <= 1'b0;
        end else if (accept) begin
            mode_q <= bad_now ? AM_PLAIN : addr_mode_e'(mode);
            sel_q  <= ptr_sel;
            disp_q <= disp;
            k_q    <= direct_addr;
            we_q   <= is_write;
            bad_q  <= bad_now;
        end
    end

    agu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .idle      (idle),
        .accept    (accept),
        .access_ph (access_ph),
        .done_ph   (done_ph)
    );

    assign ld_take = ld_en && idle && !start;
    assign wb_en   = done_ph && !bad_q && ptr_changes;

    agu_ptr_file #(.AW(AW), .NUM_PTR(NUM_PTR), .SW(SW)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_take),
        .ld_sel (ld_sel),
        .ld_val (ld_val),
        .wb_en  (wb_en),
        .wb_sel (sel_q),
        .wb_val (next_ptr),
        .rd_sel (sel_q),
        .rd_val (ptr_val)
    );

    agu_addr_calc #(.AW(AW), .QW(QW)) u_calc (
        .mode        (mode_q),
        .ptr_val     (ptr_val),
        .disp        (disp_q),
        .direct_addr (k_q),
        .eff_addr    (addr),
        .next_ptr    (next_ptr),
        .ptr_changes (ptr_changes)
    );

    assign mem_req = access_ph && !bad_q;
    assign mem_we  = mem_req && we_q;
    assign done    = done_ph;
    assign illegal = done_ph && bad_q;

    AST_REQ_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (done && !illegal)); // R3
    AST_NO_REQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && done)); // R3
    AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !$past(mem_req)); // R9
    AST_WE_ONLY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R11
endmodule

// File: tb/tb_agu_pointer_unit.sv
// Directed bench for the pointer address generator.
module tb_agu_pointer_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, is_write, ld_en;
    logic [2:0]  mode;
    logic [1:0]  ptr_sel, ld_sel;
    logic [5:0]  disp;
    logic [15:0] direct_addr, ld_val;
    logic [15:0] addr;
    logic        mem_req, mem_we, done, illegal;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    agu_pointer_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ptr_sel(ptr_sel),
        .disp(disp), .direct_addr(direct_addr), .is_write(is_write),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .addr(addr),
        .mem_req(mem_req), .mem_we(mem_we), .done(done), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_val = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // One full operation; checks request and done timing, returns address.
    task automatic run_op(input logic [2:0] m, input logic [1:0] s, input logic [5:0] q,
                          input logic [15:0] k, input logic w, input logic exp_bad,
                          input string tag, output logic [15:0] got);
        @(negedge clk);
        start = 1'b1; mode = m; ptr_sel = s; disp = q; direct_addr = k; is_write = w;
        @(negedge clk);
        start = 1'b0;
        got = addr;
        chk({tag, " R3 req"}, mem_req, !exp_bad);
        chk({tag, " R11 we"}, mem_we, !exp_bad && w);
        chk({tag, " R3 no early done"}, done, 0);
        @(negedge clk);
        chk({tag, " R3 done"}, done, 1);
        chk({tag, " R3 req low"}, mem_req, 0);
        chk({tag, " R9 illegal"}, illegal, exp_bad);
        @(negedge clk);
        chk({tag, " R3 done low"}, done, 0);
    endtask

    task automatic peek(input logic [1:0] s, input logic [15:0] exp, input string tag);
        logic [15:0] a;
        run_op(3'd0, s, 6'd0, 16'h0, 1'b0, 1'b0, {tag, " R4 peek"}, a);
        chk({tag, " pointer"}, a, exp);
    endtask

    task automatic t_reset();
        chk("R1 req after reset", mem_req, 0);
        chk("R1 done after reset", done, 0);
        peek(2'd0, 16'h0000, "R1 X");
        peek(2'd1, 16'h0000, "R1 Y");
        peek(2'd2, 16'h0000, "R1 Z");
    endtask

    task automatic t_load();
        load_ptr(2'd0, 16'h1234);
        load_ptr(2'd1, 16'h8000);
        load_ptr(2'd2, 16'hFFFF);
        peek(2'd0, 16'h1234, "R2 X");
        peek(2'd1, 16'h8000, "R2 Y");
        peek(2'd2, 16'hFFFF, "R2 Z");
    endtask

    task automatic t_plain();
        logic [15:0] a;
        run_op(3'd0, 2'd1, 6'd5, 16'h1111, 1'b0, 1'b0, "R4 plain Y", a);
        chk("R4 addr", a, 16'h8000);
        peek(2'd1, 16'h8000, "R4 Y kept");
    endtask

    task automatic t_postinc();
        logic [15:0] a;
        run_op(3'd1, 2'd2, 6'd0, 16'h0, 1'b1, 1'b0, "R5 post Z", a);
        chk("R5 addr Z", a, 16'hFFFF);
        peek(2'd2, 16'h0000, "R5 Z wrap");
        run_op(3'd1, 2'd0, 6'd0, 16'h0, 1'b0, 1'b0, "R5 post X", a);
        chk("R5 addr X", a, 16'h1234);
        peek(2'd0, 16'h1235, "R5 X step");
    endtask

    task automatic t_predec();
        logic [15:0] a;
        run_op(3'd2, 2'd0, 6'd0, 16'h0, 1'b1, 1'b0, "R6 pre X", a);
        chk("R6 addr X", a, 16'h1234);
        peek(2'd0, 16'h1234, "R6 X");
        load_ptr(2'd1, 16'h0000);
        run_op(3'd2, 2'd1, 6'd0, 16'h0, 1'b0, 1'b0, "R6 pre Y", a);
        chk("R6 addr Y wrap", a, 16'hFFFF);
        peek(2'd1, 16'hFFFF, "R6 Y wrap");
    endtask

    task automatic t_disp();
        logic [15:0] a;
        load_ptr(2'd1, 16'hFFF0);
        run_op(3'd3, 2'd1, 6'd63, 16'h0, 1'b0, 1'b0, "R7 disp Y", a);
        chk("R7 addr wrap", a, 16'h002F);
        peek(2'd1, 16'hFFF0, "R7 Y kept");
        load_ptr(2'd2, 16'h4000);
        run_op(3'd3, 2'd2, 6'd0, 16'h0, 1'b1, 1'b0, "R7 disp Z", a);
        chk("R7 addr q0", a, 16'h4000);
        run_op(3'd3, 2'd2, 6'd17, 16'h0, 1'b0, 1'b0, "R7 disp Z17", a);
        chk("R7 addr q17", a, 16'h4011);
        peek(2'd2, 16'h4000, "R7 Z kept");
    endtask

    task automatic t_direct();
        logic [15:0] a;
        run_op(3'd4, 2'd3, 6'd9, 16'hBEEF, 1'b1, 1'b0, "R8 direct", a);
        chk("R8 addr", a, 16'hBEEF);
        peek(2'd0, 16'h1234, "R8 X untouched");
        peek(2'd2, 16'h4000, "R8 Z untouched");
    endtask

    task automatic t_illegal();
        logic [15:0] a;
        run_op(3'd3, 2'd0, 6'd4, 16'h0, 1'b1, 1'b1, "R9 disp on X", a);
        peek(2'd0, 16'h1234, "R9 X kept");
        run_op(3'd5, 2'd1, 6'd0, 16'h0, 1'b0, 1'b1, "R9 mode5", a);
        run_op(3'd1, 2'd3, 6'd0, 16'h0, 1'b0, 1'b1, "R9 sel3 post", a);
        peek(2'd1, 16'hFFF0, "R9 Y kept");
        peek(2'd2, 16'h4000, "R9 Z kept");
    endtask

    task automatic t_busy();
        load_ptr(2'd1, 16'h0010);
        @(negedge clk);
        start = 1'b1; mode = 3'd1; ptr_sel = 2'd1; is_write = 1'b0;
        @(negedge clk);
        chk("R10 first req", mem_req, 1);
        chk("R10 first addr", addr, 16'h0010);
        mode = 3'd4; direct_addr = 16'hAAAA;
        ld_en = 1'b1; ld_sel = 2'd2; ld_val = 16'h5555;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk("R10 done", done, 1);
        @(negedge clk);
        chk("R10 no second req", mem_req, 0);
        peek(2'd1, 16'h0011, "R10 Y single step");
        peek(2'd2, 16'h4000, "R2 Z load ignored when busy");
        // load in the same cycle as start is ignored
        @(negedge clk);
        start = 1'b1; mode = 3'd0; ptr_sel = 2'd0;
        ld_en = 1'b1; ld_sel = 2'd0; ld_val = 16'h7777;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk("R2 load with start ignored", addr, 16'h1234);
        @(negedge clk);
        @(negedge clk);
        peek(2'd0, 16'h1234, "R2 X after start-load");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; is_write = 1'b0; ld_en = 1'b0;
        mode = 3'd0; ptr_sel = 2'd0; ld_sel = 2'd0; disp = 6'd0;
        direct_addr = 16'h0; ld_val = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_direct();
        t_illegal();
        t_busy();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule